// File: doc/BRIEF.md
# Host-Bridge Control Register Bank

This block holds the 64-bit configuration and control registers of a host bridge and serves them to two requesters. One is a scan-style port that addresses a register with its byte address shifted right by three. The other is a memory-mapped port whose byte offset lands on the same bank ten registers higher. Some indexes are not storage but modifiers. Two of them AND or OR write data into the fault register, and two of them set or clear bits of the control word.

The base-address register holds a window base and an enable bit. Only the scan port may change it. The memory-mapped port cannot move its own window, and an attempt to do so is refused. The interrupt-routing words and the interrupt-status word are plain storage here, and the status word cannot be written at all. Every refused request produces a one-cycle error pulse: an unmapped index, a write to a read-only or protected word, or a transfer narrower than eight bytes. An unmapped read also returns all ones.

Top module: `hb_regfile`

## Requirements
- R1: After reset every register reads zero, except the base register at index 0x0a, which reads (BAR_RESET AND 0x0003fffffff00000) OR 1. No ack and no error pulse appears until a request is accepted.
- R2: The scan port's register index is its address shifted right by 3. The memory-mapped port's index is its byte offset shifted right by 3, plus 0x0a. Memory offset 0x20 therefore reaches the control word at index 0x0e.
- R3: Index 0x00 is the fault register and is read/write. A write to index 0x01 ANDs the data into it, and a write to index 0x02 ORs the data into it. Indexes 0x06 and 0x07 are plain read/write.
- R4: Index 0x0e is the control word and is read/write. A write to index 0x12 ORs the data into it, and a write to index 0x13 clears every bit that is set in the data.
- R5: A scan-port write to index 0x0a stores the data ANDed with 0x0003fffffff00000, plus the data's bit 0, which is the enable.
- R6: A memory-mapped write to index 0x0a leaves the base register unchanged and pulses the error output.
- R7: A write to index 0x0b stores the data ANDed with 0x0003ffff00000000.
- R8: Index 0x15 (the interrupt status) is read-only and reads zero. A write to it is dropped and pulses the error output.
- R9: The readable indexes are 0x00, 0x06, 0x07, 0x0a, 0x0b, 0x0e, 0x0f, 0x10, 0x14, 0x15 and 0x16 to 0x1b. A read of any other index, including the alias indexes 0x01, 0x02, 0x12 and 0x13, returns 0xFFFFFFFFFFFFFFFF and pulses the error output. A write to an index that is neither readable nor an alias changes nothing and pulses the error output.
- R10: The size code is log2 of the byte count, so a full 8-byte transfer has code 3. Any other code is refused: a write changes nothing, a read returns all ones, and both pulse the error output.
- R11: The scan port always has ready high. The memory-mapped port's ready is low while scan valid is high. The ack of an accepted request, the read data and the error pulse all appear in the cycle after acceptance.
- R12: Indexes 0x0f, 0x10, 0x14 and 0x16 to 0x1b store and return all 64 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_valid_i | input | 1 | Scan request strobe |
| scan_ready_o | output | 1 | Scan request accepted (always high) |
| scan_write_i | input | 1 | 1 = write, 0 = read |
| scan_size_i | input | 3 | log2 of the byte count |
| scan_addr_i | input | ADDR_W | Scan address (index = address >> 3) |
| scan_wdata_i | input | 64 | Write data |
| scan_ack_o | output | 1 | Response pulse, one cycle after acceptance |
| scan_rdata_o | output | 64 | Read data, valid with the ack |
| mm_valid_i | input | 1 | Memory-mapped request strobe |
| mm_ready_o | output | 1 | Memory-mapped request accepted |
| mm_write_i | input | 1 | 1 = write, 0 = read |
| mm_size_i | input | 3 | log2 of the byte count |
| mm_addr_i | input | ADDR_W | Byte offset in the window |
| mm_wdata_i | input | 64 | Write data |
| mm_ack_o | output | 1 | Response pulse, one cycle after acceptance |
| mm_rdata_o | output | 64 | Read data, valid with the ack |
| err_o | output | 1 | One-cycle pulse for a refused request |

## Verification
The hardest situation to create is a memory-mapped request that arrives in the same cycle as a scan request. It must stall, then be served one cycle later, and it must see the value the scan write has just stored. The bench raises both strobes together. It checks the memory-mapped ready while it is held low. It then releases the scan strobe and reads back the word the scan request wrote. A second hard case is the protected base register: it can be reached through the memory window only by offset 0. The bench writes there from that port and then reads the register back through the scan port to show it did not change.

// File: rtl/hb_regfile_pkg.sv
package hb_regfile_pkg;

  localparam int DW     = 64;
  localparam int SLOT_W = 5;
  localparam int NSLOT  = 1 << SLOT_W;

  typedef enum logic [3:0] {
    OP_BAD, OP_READ, OP_WR_PLAIN, OP_WR_AND, OP_WR_OR,
    OP_WR_SET, OP_WR_CLR, OP_WR_BAR, OP_WR_FSPBAR
  } op_e;

  localparam logic [SLOT_W-1:0] IX_FAULT     = 5'h00;
  localparam logic [SLOT_W-1:0] IX_FAULT_AND = 5'h01;
  localparam logic [SLOT_W-1:0] IX_FAULT_OR  = 5'h02;
  localparam logic [SLOT_W-1:0] IX_ACT0      = 5'h06;
  localparam logic [SLOT_W-1:0] IX_ACT1      = 5'h07;
  localparam logic [SLOT_W-1:0] IX_BAR       = 5'h0a;
  localparam logic [SLOT_W-1:0] IX_FSPBAR    = 5'h0b;
  localparam logic [SLOT_W-1:0] IX_CTRL      = 5'h0e;
  localparam logic [SLOT_W-1:0] IX_ERRMASK   = 5'h0f;
  localparam logic [SLOT_W-1:0] IX_ROUTE0    = 5'h10;
  localparam logic [SLOT_W-1:0] IX_CTRL_SET  = 5'h12;
  localparam logic [SLOT_W-1:0] IX_CTRL_CLR  = 5'h13;
  localparam logic [SLOT_W-1:0] IX_DMAHI     = 5'h14;
  localparam logic [SLOT_W-1:0] IX_ISTAT     = 5'h15;
  localparam logic [SLOT_W-1:0] IX_ROUTE_LO  = 5'h16;
  localparam logic [SLOT_W-1:0] IX_ROUTE_HI  = 5'h1b;

  localparam int MM_IDX_BASE = 10;

  // plain full-width read/write words
  function automatic logic slot_plain(input int s);
    return s == int'(IX_FAULT) || s == int'(IX_ACT0) || s == int'(IX_ACT1) ||
           s == int'(IX_CTRL) || s == int'(IX_ERRMASK) || s == int'(IX_ROUTE0) ||
           s == int'(IX_DMAHI) ||
           (s >= int'(IX_ROUTE_LO) && s <= int'(IX_ROUTE_HI));
  endfunction

  function automatic logic slot_readable(input int s);
    return slot_plain(s) || s == int'(IX_BAR) || s == int'(IX_FSPBAR) ||
           s == int'(IX_ISTAT);
  endfunction

endpackage

// File: rtl/hb_port.sv
module hb_port #(
  parameter int ADDR_W   = 16,
  parameter int IDX_W    = ADDR_W - 2,
  parameter int IDX_BASE = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int SH_W = ADDR_W - 3;

  logic [SH_W-1:0] word;
  assign word  = addr_i[ADDR_W-1:3];
  assign idx_o = IDX_W'(word) + IDX_W'(IDX_BASE);
endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hb_regfile_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              write_i,
  input  logic              from_mm_i,
  input  logic [2:0]        size_i,
  output op_e               op_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic              in_range;
  logic [SLOT_W-1:0] s;

  assign in_range = (idx_i >> SLOT_W) == '0;
  assign s        = idx_i[SLOT_W-1:0];

  always_comb begin
    op_o   = OP_BAD;
    slot_o = s;
    if (size_i == 3'd3 && in_range) begin
      if (!write_i) begin
        op_o = slot_readable(int'(s)) ? OP_READ : OP_BAD;
      end else begin
        unique case (s)
          IX_FAULT_AND: begin op_o = OP_WR_AND; slot_o = IX_FAULT; end
          IX_FAULT_OR:  begin op_o = OP_WR_OR;  slot_o = IX_FAULT; end
          IX_CTRL_SET:  begin op_o = OP_WR_SET; slot_o = IX_CTRL;  end
          IX_CTRL_CLR:  begin op_o = OP_WR_CLR; slot_o = IX_CTRL;  end
          IX_BAR:       op_o = from_mm_i ? OP_BAD : OP_WR_BAR;
          IX_FSPBAR:    op_o = OP_WR_FSPBAR;
          IX_ISTAT:     op_o = OP_BAD;
          default:      op_o = slot_plain(int'(s)) ? OP_WR_PLAIN : OP_BAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/hb_bank.sv
module hb_bank
  import hb_regfile_pkg::*;
#(
  parameter logic [DW-1:0] BAR_RESET   = 64'h0000_0060_3020_0000,
  parameter logic [DW-1:0] BAR_MASK    = 64'h0003_ffff_fff0_0000,
  parameter logic [DW-1:0] FSPBAR_MASK = 64'h0003_ffff_0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  op_e               op_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic [DW-1:0]     bar_o
);
  localparam logic [DW-1:0] BAR_RST_VAL = (BAR_RESET & BAR_MASK) | 64'h1;

  logic [DW-1:0] slot_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (slot_readable(i)) begin : g_st
      localparam logic [DW-1:0] RST = (i == int'(IX_BAR)) ? BAR_RST_VAL : '0;
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= RST;
        end else if (go_i && slot_i == SLOT_W'(i)) begin
          case (op_i)
            OP_WR_PLAIN:  q <= wdata_i;
            OP_WR_AND:    q <= q & wdata_i;
            OP_WR_OR,
            OP_WR_SET:    q <= q | wdata_i;
            OP_WR_CLR:    q <= q & ~wdata_i;
            OP_WR_BAR:    q <= wdata_i & (BAR_MASK | 64'h1);
            OP_WR_FSPBAR: q <= wdata_i & FSPBAR_MASK;
            default:      q <= q;
          endcase
        end
      end
      assign slot_q[i] = q;
    end else begin : g_none
      assign slot_q[i] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= go_i && op_i == OP_BAD;
      if (go_i) rdata_o <= (op_i == OP_READ) ? slot_q[slot_i] : '1;
    end
  end

  assign bar_o = slot_q[IX_BAR];

  AST_FAULT_OR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && op_i == OP_WR_OR) |=>
      ((slot_q[IX_FAULT] & $past(wdata_i)) == $past(wdata_i))); // R3

  AST_CTRL_CLR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && op_i == OP_WR_CLR) |=>
      ((slot_q[IX_CTRL] & $past(wdata_i)) == '0)); // R4
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile
  import hb_regfile_pkg::*;
#(
  parameter int            ADDR_W      = 16,
  parameter logic [63:0]   BAR_RESET   = 64'h0000_0060_3020_0000,
  parameter logic [63:0]   BAR_MASK    = 64'h0003_ffff_fff0_0000,
  parameter logic [63:0]   FSPBAR_MASK = 64'h0003_ffff_0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_valid_i,
  output logic              scan_ready_o,
  input  logic              scan_write_i,
  input  logic [2:0]        scan_size_i,
  input  logic [ADDR_W-1:0] scan_addr_i,
  input  logic [63:0]       scan_wdata_i,
  output logic              scan_ack_o,
  output logic [63:0]       scan_rdata_o,
  input  logic              mm_valid_i,
  output logic              mm_ready_o,
  input  logic              mm_write_i,
  input  logic [2:0]        mm_size_i,
  input  logic [ADDR_W-1:0] mm_addr_i,
  input  logic [63:0]       mm_wdata_i,
  output logic              mm_ack_o,
  output logic [63:0]       mm_rdata_o,
  output logic              err_o
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int NPORT  = 2;
  localparam int P_SCAN = 0;
  localparam int P_MM   = 1;

  logic [ADDR_W-1:0] addr_a [NPORT];
  logic [IDX_W-1:0]  idx_a  [NPORT];

  assign addr_a[P_SCAN] = scan_addr_i;
  assign addr_a[P_MM]   = mm_addr_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    hb_port #(
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W),
      .IDX_BASE((p == P_MM) ? MM_IDX_BASE : 0)
    ) u_port (
      .addr_i(addr_a[p]),
      .idx_o (idx_a[p])
    );
  end

  // fixed priority: scan port wins
  logic              go, sel_mm, wr;
  logic [2:0]        size;
  logic [IDX_W-1:0]  idx;
  logic [63:0]       wdata;
  op_e               op;
  logic [SLOT_W-1:0] slot;
  logic [63:0]       rdata, bar;
  logic              scan_ack_q, mm_ack_q;

  assign scan_ready_o = 1'b1;
  assign mm_ready_o   = !scan_valid_i;
  assign go           = scan_valid_i || mm_valid_i;
  assign sel_mm       = !scan_valid_i;
  assign wr           = sel_mm ? mm_write_i : scan_write_i;
  assign size         = sel_mm ? mm_size_i  : scan_size_i;
  assign idx          = sel_mm ? idx_a[P_MM] : idx_a[P_SCAN];
  assign wdata        = sel_mm ? mm_wdata_i : scan_wdata_i;

  hb_decode #(.IDX_W(IDX_W)) u_dec (
    .idx_i    (idx),
    .write_i  (wr),
    .from_mm_i(sel_mm),
    .size_i   (size),
    .op_o     (op),
    .slot_o   (slot)
  );

  hb_bank #(
    .BAR_RESET  (BAR_RESET),
    .BAR_MASK   (BAR_MASK),
    .FSPBAR_MASK(FSPBAR_MASK)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .op_i   (op),
    .slot_i (slot),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .err_o  (err_o),
    .bar_o  (bar)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_ack_q <= 1'b0;
      mm_ack_q   <= 1'b0;
    end else begin
      scan_ack_q <= scan_valid_i;
      mm_ack_q   <= mm_valid_i && !scan_valid_i;
    end
  end

  assign scan_ack_o   = scan_ack_q;
  assign mm_ack_o     = mm_ack_q;
  assign scan_rdata_o = rdata;
  assign mm_rdata_o   = rdata;

  AST_MM_BAR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_valid_i && !scan_valid_i && mm_write_i && mm_size_i == 3'd3 &&
     idx_a[P_MM] == IDX_W'(IX_BAR)) |=> (err_o && $stable(bar))); // R6

  AST_NARROW_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && size != 3'd3) |=> (err_o && rdata == '1)); // R10

  AST_SCAN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_valid_i && mm_valid_i) |=> (scan_ack_o && !mm_ack_o)); // R11

  AST_UNMAPPED_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !wr && op == OP_BAD) |=> (err_o && rdata == '1)); // R9
endmodule

// File: tb/tb_hb_regfile.sv
`timescale 1ns/1ps
module tb_hb_regfile;
  localparam int          ADDR_W = 16;
  localparam logic [63:0] BAR_RESET   = 64'h0000_0060_3020_0000;
  localparam logic [63:0] BAR_MASK    = 64'h0003_ffff_fff0_0000;
  localparam logic [63:0] FSPBAR_MASK = 64'h0003_ffff_0000_0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scan_valid_i = 0, scan_write_i = 0, mm_valid_i = 0, mm_write_i = 0;
  logic [2:0] scan_size_i = 3, mm_size_i = 3;
  logic [ADDR_W-1:0] scan_addr_i = '0, mm_addr_i = '0;
  logic [63:0] scan_wdata_i = '0, mm_wdata_i = '0;
  logic scan_ready_o, scan_ack_o, mm_ready_o, mm_ack_o, err_o;
  logic [63:0] scan_rdata_o, mm_rdata_o;

  always #2.5 clk = ~clk;

  hb_regfile #(.ADDR_W(ADDR_W), .BAR_RESET(BAR_RESET), .BAR_MASK(BAR_MASK),
               .FSPBAR_MASK(FSPBAR_MASK)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .scan_valid_i(scan_valid_i), .scan_ready_o(scan_ready_o),
    .scan_write_i(scan_write_i), .scan_size_i(scan_size_i),
    .scan_addr_i(scan_addr_i), .scan_wdata_i(scan_wdata_i),
    .scan_ack_o(scan_ack_o), .scan_rdata_o(scan_rdata_o),
    .mm_valid_i(mm_valid_i), .mm_ready_o(mm_ready_o),
    .mm_write_i(mm_write_i), .mm_size_i(mm_size_i),
    .mm_addr_i(mm_addr_i), .mm_wdata_i(mm_wdata_i),
    .mm_ack_o(mm_ack_o), .mm_rdata_o(mm_rdata_o),
    .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] mdl [32];

  function automatic bit m_readable(int i);
    return i == 0 || i == 6 || i == 7 || i == 10 || i == 11 || i == 14 ||
           i == 15 || i == 16 || i == 20 || i == 21 || (i >= 22 && i <= 27);
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference behaviour of one accepted request; returns expected err and read data
  task automatic model(bit mm, bit wr, int addr, bit [2:0] sz, logic [63:0] d,
                       output bit bad, output logic [63:0] rd);
    int ix = mm ? (addr >> 3) + 10 : (addr >> 3);
    bad = 0;
    rd  = '1;
    if (sz != 3 || ix > 31) bad = 1;
    else if (!wr) begin
      if (m_readable(ix)) rd = mdl[ix]; else bad = 1;
    end else begin
      case (ix)
        0, 6, 7, 14, 15, 16, 20, 22, 23, 24, 25, 26, 27: mdl[ix] = d;
        1:  mdl[0]  = mdl[0] & d;
        2:  mdl[0]  = mdl[0] | d;
        18: mdl[14] = mdl[14] | d;
        19: mdl[14] = mdl[14] & ~d;
        10: if (mm) bad = 1; else mdl[10] = d & (BAR_MASK | 64'h1);
        11: mdl[11] = d & FSPBAR_MASK;
        default: bad = 1;
      endcase
    end
  endtask

  // entered and left at a falling edge
  task automatic acc(bit mm, bit wr, int addr, bit [2:0] sz, logic [63:0] d, string tag);
    bit bad;
    logic [63:0] rd;
    model(mm, wr, addr, sz, d, bad, rd);
    if (mm) begin
      mm_valid_i = 1; mm_write_i = wr; mm_addr_i = ADDR_W'(addr);
      mm_size_i = sz; mm_wdata_i = d;
    end else begin
      scan_valid_i = 1; scan_write_i = wr; scan_addr_i = ADDR_W'(addr);
      scan_size_i = sz; scan_wdata_i = d;
    end
    @(negedge clk);
    check((mm ? mm_ack_o : scan_ack_o) == 1'b1, {tag, " ack"},
          64'(mm ? mm_ack_o : scan_ack_o), 64'd1);
    check(err_o == bad, {tag, " err"}, 64'(err_o), 64'(bad));
    if (!wr) check((mm ? mm_rdata_o : scan_rdata_o) == rd, {tag, " rdata"},
                   mm ? mm_rdata_o : scan_rdata_o, rd);
    scan_valid_i = 0;
    mm_valid_i   = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    mdl[10] = (BAR_RESET & BAR_MASK) | 64'h1;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    check(!scan_ack_o && !mm_ack_o && !err_o, "R1 idle outputs",
          64'({scan_ack_o, mm_ack_o, err_o}), 64'd0);
    acc(0, 0, 'h50, 3, 0, "R1 bar reset");
    acc(0, 0, 'h00, 3, 0, "R1 fault reset");
    acc(0, 0, 'h70, 3, 0, "R1 ctrl reset");
    acc(0, 0, 'ha8, 3, 0, "R1 istat reset");
    // R12 plain storage
    acc(0, 1, 'h78, 3, 64'hdead_beef_0123_4567, "R12 wr errmask");
    acc(0, 0, 'h78, 3, 0, "R12 rd errmask");
    acc(0, 1, 'hd8, 3, 64'hffff_0000_a5a5_5a5a, "R12 wr route hi");
    acc(0, 0, 'hd8, 3, 0, "R12 rd route hi");
    acc(0, 1, 'ha0, 3, 64'h8000_0000_0000_0001, "R12 wr dmahi");
    acc(0, 0, 'ha0, 3, 0, "R12 rd dmahi");
    // R3 fault register and aliases
    acc(0, 1, 'h00, 3, 64'hf0f0_f0f0_1234_5678, "R3 wr fault");
    acc(0, 1, 'h08, 3, 64'hff00_ff00_ffff_0000, "R3 and alias");
    acc(0, 0, 'h00, 3, 0, "R3 rd after and");
    acc(0, 1, 'h10, 3, 64'h0000_000f_0000_0003, "R3 or alias");
    acc(0, 0, 'h00, 3, 0, "R3 rd after or");
    acc(0, 1, 'h30, 3, 64'h1111_2222_3333_4444, "R3 wr act0");
    acc(0, 1, 'h38, 3, 64'h5555_6666_7777_8888, "R3 wr act1");
    acc(0, 0, 'h30, 3, 0, "R3 rd act0");
    acc(0, 0, 'h38, 3, 0, "R3 rd act1");
    // R4 control word and aliases
    acc(0, 1, 'h70, 3, 64'h8400_0000_0000_00f0, "R4 wr ctrl");
    acc(0, 1, 'h90, 3, 64'h4000_0000_0000_000f, "R4 set alias");
    acc(0, 0, 'h70, 3, 0, "R4 rd after set");
    acc(0, 1, 'h98, 3, 64'h8000_0000_0000_0030, "R4 clr alias");
    acc(0, 0, 'h70, 3, 0, "R4 rd after clr");
    // R2 mm mapping: offset 0x20 -> ctrl, 0x28 -> errmask
    acc(1, 0, 'h20, 3, 0, "R2 mm rd ctrl");
    acc(1, 0, 'h28, 3, 0, "R2 mm rd errmask");
    acc(1, 1, 'h50, 3, 64'h0bad_cafe_0000_0001, "R2 mm wr dmahi");
    acc(0, 0, 'ha0, 3, 0, "R2 scan sees mm write");
    // R5 scan base writes
    acc(0, 1, 'h50, 3, 64'hffff_ffff_ffff_ffff, "R5 wr bar ones");
    acc(0, 0, 'h50, 3, 0, "R5 rd bar ones");
    acc(0, 1, 'h50, 3, 64'h0001_2345_6789_abce, "R5 wr bar no en");
    acc(0, 0, 'h50, 3, 0, "R5 rd bar no en");
    // R6 mm base write refused
    acc(1, 1, 'h00, 3, 64'h0003_0000_0000_0001, "R6 mm wr bar");
    acc(0, 0, 'h50, 3, 0, "R6 bar unchanged");
    acc(1, 0, 'h00, 3, 0, "R6 mm rd bar");
    // R7 FSP base mask
    acc(1, 1, 'h08, 3, 64'hffff_ffff_ffff_ffff, "R7 wr fspbar");
    acc(0, 0, 'h58, 3, 0, "R7 rd fspbar");
    // R8 read-only status
    acc(0, 1, 'ha8, 3, 64'hffff_ffff_ffff_ffff, "R8 wr istat");
    acc(0, 0, 'ha8, 3, 0, "R8 rd istat");
    acc(1, 1, 'h58, 3, 64'h1234, "R8 mm wr istat");
    acc(1, 0, 'h58, 3, 0, "R8 mm rd istat");
    // R9 unmapped
    acc(0, 0, 'h18, 3, 0, "R9 rd idx3");
    acc(0, 0, 'h08, 3, 0, "R9 rd and alias");
    acc(0, 0, 'h98, 3, 0, "R9 rd clr alias");
    acc(0, 0, 'h88, 3, 0, "R9 rd idx11h");
    acc(0, 1, 'h88, 3, 64'h77, "R9 wr idx11h");
    acc(0, 1, 'he0, 3, 64'h77, "R9 wr idx1c");
    acc(0, 0, 'h1000, 3, 0, "R9 rd far idx");
    acc(1, 0, 'h90, 3, 0, "R9 mm rd beyond");
    // R10 narrow access
    acc(0, 1, 'h78, 2, 64'h0, "R10 narrow wr");
    acc(0, 0, 'h78, 3, 0, "R10 errmask unchanged");
    acc(1, 1, 'h20, 0, 64'hffff_ffff_ffff_ffff, "R10 mm narrow wr");
    acc(0, 0, 'h70, 3, 0, "R10 ctrl unchanged");
    acc(0, 0, 'h00, 1, 0, "R10 narrow rd");
    // R11 contention: scan writes errmask, mm reads it in the same cycle
    scan_valid_i = 1; scan_write_i = 1; scan_addr_i = 'h78; scan_size_i = 3;
    scan_wdata_i = 64'h0f1e_2d3c_4b5a_6978;
    mm_valid_i = 1; mm_write_i = 0; mm_addr_i = 'h28; mm_size_i = 3;
    mdl[15] = 64'h0f1e_2d3c_4b5a_6978;
    #1;
    check(mm_ready_o == 0 && scan_ready_o == 1, "R11 mm stalled",
          64'({scan_ready_o, mm_ready_o}), 64'd2);
    @(negedge clk);
    check(scan_ack_o && !mm_ack_o && !err_o, "R11 scan served first",
          64'({scan_ack_o, mm_ack_o, err_o}), 64'd4);
    scan_valid_i = 0;
    #1;
    check(mm_ready_o == 1, "R11 mm ready after scan", 64'(mm_ready_o), 64'd1);
    @(negedge clk);
    check(mm_ack_o && !scan_ack_o && !err_o, "R11 mm served next",
          64'({scan_ack_o, mm_ack_o, err_o}), 64'd2);
    check(mm_rdata_o == mdl[15], "R11 mm sees scan write", mm_rdata_o, mdl[15]);
    mm_valid_i = 0;
    @(negedge clk);
    check(!scan_ack_o && !mm_ack_o && !err_o, "R11 acks single cycle",
          64'({scan_ack_o, mm_ack_o, err_o}), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule